// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits in front of the ALU of a five-stage, in-order integer pipeline. For each of the two source register numbers of the instruction now in execute, it checks whether one of the two older instructions still in flight will write that register. The older instructions are the one in the memory stage (EX/MEM) and the one in write-back (MEM/WB). When a match is found, the operand comes from that in-flight result, not from the stale register-file read.

The block is purely combinational. It drives a 2-bit select code for each ALU input and the selected operand value in the same cycle. Register zero is hard-wired to zero and is never a forwarding target. When both older stages write the matching register, the younger EX/MEM result wins.

The register file writes in the first half of a cycle and reads in the second half. An instruction three stages behind its producer therefore already reads the correct value, and no third forwarding path is needed.

Top module: `exfwd_sel`

## Requirements
- R1: With no qualifying match, a select output is 2'b00 and its operand equals the register-file value for that source.
- R2: When the EX/MEM write enable is 1, its destination is non-zero and it equals a source number, that select is 2'b10 and the operand equals the EX/MEM result.
- R3: When only MEM/WB qualifies (write enable 1, non-zero destination equal to the source), that select is 2'b01 and the operand equals the MEM/WB value.
- R4: When both EX/MEM and MEM/WB qualify for the same source, the select is 2'b10 and the EX/MEM result is used.
- R5: A destination number of 0 never causes forwarding, even with its write enable set and a source number of 0.
- R6: A stage whose write enable is 0 never causes forwarding, even when its destination matches.
- R7: The two operands are resolved independently: each may take a different source, or both may take the same stage's result.
- R8: Outputs depend only on the present inputs, with no clock or stored state; a change of any input is reflected without waiting for a clock edge.
- R9: When one producer feeds the next three consumers, the first consumer selects 2'b10, the second 2'b01 and the third 2'b00.
- R10: The select value 2'b11 never appears on either select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the executing instruction |
| src_b_idx | input | 5 | Second source register number of the executing instruction |
| rf_a_data | input | 32 | Register-file value read for the first source |
| rf_b_data | input | 32 | Register-file value read for the second source |
| exm_wr_en | input | 1 | EX/MEM stage will write a register |
| exm_dst_idx | input | 5 | EX/MEM destination register number |
| exm_result | input | 32 | EX/MEM ALU result |
| mwb_wr_en | input | 1 | MEM/WB stage will write a register |
| mwb_dst_idx | input | 5 | MEM/WB destination register number |
| mwb_result | input | 32 | MEM/WB write-back value |
| sel_a | output | 2 | Select for ALU input A (00 register file, 10 EX/MEM, 01 MEM/WB) |
| sel_b | output | 2 | Select for ALU input B, same encoding |
| opnd_a | output | 32 | Operand delivered to ALU input A |
| opnd_b | output | 32 | Operand delivered to ALU input B |

## Verification
The block has no state, so any fault shows on the ports in the same evaluation as the inputs that expose it. A faulty comparator or priority term shows as a wrong select code, and the operand then carries the value of another stage. The bench gives each data source a distinct value, so the operand identifies which path was taken, and the select code is checked alongside it. Faults in the register-zero and write-enable qualification only show when a destination equals the source, so the bench creates exactly those collisions.

// File: rtl/exfwd_sel.sv
module exfwd_sel #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic [RW-1:0] src_a_idx,
  input  logic [RW-1:0] src_b_idx,
  input  logic [DW-1:0] rf_a_data,
  input  logic [DW-1:0] rf_b_data,
  input  logic          exm_wr_en,
  input  logic [RW-1:0] exm_dst_idx,
  input  logic [DW-1:0] exm_result,
  input  logic          mwb_wr_en,
  input  logic [RW-1:0] mwb_dst_idx,
  input  logic [DW-1:0] mwb_result,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MWB = 2'b01;
  localparam logic [1:0] SEL_EXM = 2'b10;

  // A stage qualifies only if it writes a non-zero register.
  logic exm_live, mwb_live;
  assign exm_live = exm_wr_en && (exm_dst_idx != '0);
  assign mwb_live = mwb_wr_en && (mwb_dst_idx != '0);

  function automatic logic [1:0] pick(input logic [RW-1:0] src);
    if (exm_live && exm_dst_idx == src)      return SEL_EXM;
    else if (mwb_live && mwb_dst_idx == src) return SEL_MWB;
    else                                      return SEL_RF;
  endfunction

  assign sel_a = pick(src_a_idx);
  assign sel_b = pick(src_b_idx);

  always_comb begin
    unique case (sel_a)
      SEL_EXM: opnd_a = exm_result;
      SEL_MWB: opnd_a = mwb_result;
      default: opnd_a = rf_a_data;
    endcase
    unique case (sel_b)
      SEL_EXM: opnd_b = exm_result;
      SEL_MWB: opnd_b = mwb_result;
      default: opnd_b = rf_b_data;
    endcase
  end

  always_comb begin
    if (!$isunknown({src_a_idx, src_b_idx, exm_wr_en, exm_dst_idx, mwb_wr_en, mwb_dst_idx})) begin
      AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11); // R10
      AST_ZERO_NOFWD: assert (!(exm_dst_idx == '0 && mwb_dst_idx == '0) ||
                              (sel_a == SEL_RF && sel_b == SEL_RF)); // R5
      AST_WREN_OFF: assert (exm_wr_en || mwb_wr_en ||
                            (opnd_a == rf_a_data && opnd_b == rf_b_data)); // R6
      AST_EXM_PRIO: assert (!(exm_wr_en && exm_dst_idx != '0 && exm_dst_idx == src_a_idx) ||
                            opnd_a == exm_result); // R4
    end
  end

endmodule

// File: tb/exfwd_sel_tb.sv
module exfwd_sel_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  src_a_idx, src_b_idx, exm_dst_idx, mwb_dst_idx;
  logic [31:0] rf_a_data, rf_b_data, exm_result, mwb_result;
  logic        exm_wr_en, mwb_wr_en;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int total = 0;
  int bad = 0;

  localparam logic [31:0] VA = 32'hAAAA_0001, VB = 32'hBBBB_0002;
  localparam logic [31:0] VE = 32'hEEEE_0003, VW = 32'h7777_0004;

  exfwd_sel dut_i (.*);

  task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                       input logic ew, input logic [4:0] ed,
                       input logic mw, input logic [4:0] md);
    @(negedge clk);
    src_a_idx = sa; src_b_idx = sb;
    exm_wr_en = ew; exm_dst_idx = ed;
    mwb_wr_en = mw; mwb_dst_idx = md;
    rf_a_data = VA; rf_b_data = VB; exm_result = VE; mwb_result = VW;
    #1;
  endtask

  task automatic chk(input string req, input logic [1:0] es_a, input logic [31:0] eo_a,
                     input logic [1:0] es_b, input logic [31:0] eo_b);
    total++;
    if (sel_a !== es_a || opnd_a !== eo_a || sel_b !== es_b || opnd_b !== eo_b) begin
      bad++;
      $display("FAIL %s: sel_a=%b opnd_a=%h sel_b=%b opnd_b=%h exp %b %h %b %h",
               req, sel_a, opnd_a, sel_b, opnd_b, es_a, eo_a, es_b, eo_b);
    end
  endtask

  task automatic t_nomatch;  // R1
    drive(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8);
    chk("R1", 2'b00, VA, 2'b00, VB);
    drive(5'd0, 5'd31, 1'b0, 5'd0, 1'b0, 5'd0);
    chk("R1 reset-like idle", 2'b00, VA, 2'b00, VB);
  endtask

  task automatic t_exm;  // R2
    drive(5'd9, 5'd4, 1'b1, 5'd9, 1'b0, 5'd0);
    chk("R2 a", 2'b10, VE, 2'b00, VB);
    drive(5'd1, 5'd31, 1'b1, 5'd31, 1'b0, 5'd0);
    chk("R2 b", 2'b00, VA, 2'b10, VE);
  endtask

  task automatic t_mwb;  // R3
    drive(5'd12, 5'd4, 1'b1, 5'd5, 1'b1, 5'd12);
    chk("R3 a", 2'b01, VW, 2'b00, VB);
    drive(5'd1, 5'd6, 1'b0, 5'd6, 1'b1, 5'd6);
    chk("R3 b ex disabled", 2'b00, VA, 2'b01, VW);
  endtask

  task automatic t_prio;  // R4
    drive(5'd10, 5'd10, 1'b1, 5'd10, 1'b1, 5'd10);
    chk("R4", 2'b10, VE, 2'b10, VE);
  endtask

  task automatic t_zero;  // R5
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    chk("R5 both zero", 2'b00, VA, 2'b00, VB);
    drive(5'd0, 5'd2, 1'b1, 5'd0, 1'b1, 5'd2);
    chk("R5 exm zero", 2'b00, VA, 2'b01, VW);
  endtask

  task automatic t_wren;  // R6
    drive(5'd5, 5'd5, 1'b0, 5'd5, 1'b0, 5'd5);
    chk("R6", 2'b00, VA, 2'b00, VB);
  endtask

  task automatic t_indep;  // R7
    drive(5'd3, 5'd8, 1'b1, 5'd3, 1'b1, 5'd8);
    chk("R7 split", 2'b10, VE, 2'b01, VW);
    drive(5'd8, 5'd3, 1'b1, 5'd3, 1'b1, 5'd8);
    chk("R7 swap", 2'b01, VW, 2'b10, VE);
  endtask

  task automatic t_comb;  // R8: change mid-cycle without an edge
    drive(5'd6, 5'd7, 1'b1, 5'd6, 1'b0, 5'd0);
    chk("R8 before", 2'b10, VE, 2'b00, VB);
    exm_result = 32'h1234_5678; mwb_dst_idx = 5'd7; mwb_wr_en = 1'b1;
    #1;
    chk("R8 after", 2'b10, 32'h1234_5678, 2'b01, VW);
  endtask

  task automatic t_chain;  // R9: producer writes r2
    drive(5'd2, 5'd5, 1'b1, 5'd2, 1'b1, 5'd9);
    chk("R9 first", 2'b10, VE, 2'b00, VB);
    drive(5'd6, 5'd2, 1'b1, 5'd12, 1'b1, 5'd2);
    chk("R9 second", 2'b00, VA, 2'b01, VW);
    drive(5'd2, 5'd2, 1'b1, 5'd13, 1'b1, 5'd12);
    chk("R9 third", 2'b00, VA, 2'b00, VB);
  endtask

  task automatic t_legal;  // R10
    for (int i = 0; i < 32; i++) begin
      drive(i[4:0], 5'(31 - i), 1'b1, 5'(i % 4), 1'b1, 5'(i % 3));
      total++;
      if (sel_a == 2'b11 || sel_b == 2'b11) begin
        bad++;
        $display("FAIL R10: sel_a=%b sel_b=%b exp not 11", sel_a, sel_b);
      end
    end
  endtask

  initial begin
    fork
      begin
        t_nomatch(); t_exm(); t_mwb(); t_prio(); t_zero();
        t_wren(); t_indep(); t_comb(); t_chain(); t_legal();
      end
      begin
        repeat (10000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, exp completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule